// File: doc/BRIEF.md
# In-System Programming Sequence Controller

This block steps a reprogrammable logic device through its in-system programming flow. A separate serial shifter carries instructions, addresses and data into the device and brings readback out. The controller drives that shifter through a request/done handshake. Between shifts it times the fixed-length stages and pulses with a single down-counter. The millisecond-scale waits are derived from a clocks-per-millisecond parameter.

A start pulse launches a run in one of two modes, latched at that start:

- **Full run:** enter, check the silicon ID, bulk erase, program every address, verify every address, exit.
- **Verify-only run:** enter, check the ID, verify, exit.

While a run is in progress, `busy_o` is high and `stage_o` shows the active stage. At the end, `done_o` pulses once and `pass_o` holds the outcome.

Top module: `isp_seq_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, shift_req_o and pulse_o are 0 and stage_o is 7 (idle).
- R2: A full run shows stage_o values 0 (enter), 1 (ID check), 2 (erase), 3 (program), 4 (verify), 5 (exit) in that order, with stage_o never decreasing while busy_o is high.
- R3: A run started with verify_only_i high shows only stages 0, 1, 4, 5, with no erase shift and no program shift.
- R4: The enter and exit stages each last CPM cycles. The start-to-done time is the sum of all stage times, with each shift lasting as long as the shifter takes to answer.
- R5: The erase stage issues one shift with op 1 and then holds pulse_o high for ERASE_MS*CPM cycles.
- R6: The program stage visits addresses 0 to ADDRS-1 in ascending order. For each address it issues one shift with op 2, carrying that address and exp_data_i on shift_wdata_o, and then holds pulse_o for PROG_CYC cycles.
- R7: The verify stage does the following for each address from 0 upward: a shift with op 3, then pulse_o for READ_CYC cycles, then a readback shift with op 4. Each readback is compared with exp_data_i. A mismatch makes the result fail, but every address is still visited.
- R8: The ID check is a shift with op 0. If its readback differs from ID_VAL, the controller goes straight to the exit stage and the result is fail.
- R9: start_i is ignored while busy_o is high, and the mode is taken only at the accepted start.
- R10: done_o is high for exactly one cycle, in the same cycle that busy_o first falls. pass_o is 0 from the accepted start until done_o, then holds the result until the next accepted start.
- R11: shift_req_o stays high, with shift_op_o and shift_addr_o stable, until shift_done_i is seen. shift_req_o and pulse_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| verify_only_i | input | 1 | Mode sampled at start: 1 = verify-only run |
| shift_req_o | output | 1 | Request to the serial shifter |
| shift_op_o | output | 3 | Shift kind: 0 ID read, 1 erase, 2 program, 3 verify address, 4 readback |
| shift_addr_o | output | AW | Device memory address for the shift |
| shift_wdata_o | output | DW | Data to program |
| shift_done_i | input | 1 | Shifter finished the current request |
| shift_rdata_i | input | DW | Data shifted out, valid with shift_done_i |
| exp_data_i | input | DW | Expected contents of shift_addr_o |
| pulse_o | output | 1 | Erase, program or read pulse active |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Result of the last run |
| stage_o | output | 3 | Current stage, 7 when idle |

## Verification
An accepted start is registered at the same edge that samples it, so busy_o is already high and pass_o low one cycle later. A shift request answered on a given cycle moves the controller on at the next edge. Every wait of N cycles occupies exactly N cycles, so done_o rises after a number of edges that the bench adds up from the stage lengths and the responder's fixed two-cycle latency. The bench counts edges from the start and requires done_o at exactly that count. It checks done_o one edge later for the drop and pass_o for hold. Pulse lengths and per-address shifts are tallied cycle by cycle while the run is in flight.

// File: rtl/isp_seq_ctrl.sv
module isp_seq_ctrl #(
  parameter int CPM      = 50000,
  parameter int ERASE_MS = 100,
  parameter int PROG_CYC = 64,
  parameter int READ_CYC = 8,
  parameter int ADDRS    = 256,
  parameter int DW       = 8,
  parameter logic [DW-1:0] ID_VAL = 'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          verify_only_i,
  output logic          shift_req_o,
  output logic [2:0]    shift_op_o,
  output logic [((ADDRS > 1) ? $clog2(ADDRS) : 1)-1:0] shift_addr_o,
  output logic [DW-1:0] shift_wdata_o,
  input  logic          shift_done_i,
  input  logic [DW-1:0] shift_rdata_i,
  input  logic [DW-1:0] exp_data_i,
  output logic          pulse_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [2:0]    stage_o
);
  localparam int AW = (ADDRS > 1) ? $clog2(ADDRS) : 1;
  localparam int ERASE_CYC = ERASE_MS * CPM;
  localparam int M1 = (ERASE_CYC > CPM) ? ERASE_CYC : CPM;
  localparam int M2 = (PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    IDLE, ENTER, ID_SH, ER_SH, ER_WT, PG_SH, PG_WT, VF_SH, VF_WT, VF_RD, EXIT
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic vonly, fail, pass_q, done_q;

  wire cnt_end = (cnt == '0);
  wire last    = (addr == AW'(ADDRS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      addr <= '0;
      vonly <= 1'b0;
      fail <= 1'b0;
      pass_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (start_i) begin
          st <= ENTER;
          cnt <= CW'(CPM - 1);
          vonly <= verify_only_i;
          fail <= 1'b0;
          pass_q <= 1'b0;
        end
        ENTER: if (cnt_end) st <= ID_SH; else cnt <= cnt - 1'b1;
        ID_SH: if (shift_done_i) begin
          if (shift_rdata_i != ID_VAL) begin
            fail <= 1'b1;
            st <= EXIT;
            cnt <= CW'(CPM - 1);
          end else if (vonly) begin
            st <= VF_SH;
            addr <= '0;
          end else st <= ER_SH;
        end
        ER_SH: if (shift_done_i) begin
          st <= ER_WT;
          cnt <= CW'(ERASE_CYC - 1);
        end
        ER_WT: if (cnt_end) begin
          st <= PG_SH;
          addr <= '0;
        end else cnt <= cnt - 1'b1;
        PG_SH: if (shift_done_i) begin
          st <= PG_WT;
          cnt <= CW'(PROG_CYC - 1);
        end
        PG_WT: if (cnt_end) begin
          if (last) begin
            st <= VF_SH;
            addr <= '0;
          end else begin
            st <= PG_SH;
            addr <= addr + 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        VF_SH: if (shift_done_i) begin
          st <= VF_WT;
          cnt <= CW'(READ_CYC - 1);
        end
        VF_WT: if (cnt_end) st <= VF_RD; else cnt <= cnt - 1'b1;
        VF_RD: if (shift_done_i) begin
          if (shift_rdata_i != exp_data_i) fail <= 1'b1;
          if (last) begin
            st <= EXIT;
            cnt <= CW'(CPM - 1);
          end else begin
            st <= VF_SH;
            addr <= addr + 1'b1;
          end
        end
        EXIT: if (cnt_end) begin
          st <= IDLE;
          done_q <= 1'b1;
          pass_q <= !fail;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    shift_op_o = 3'd0;
    stage_o = 3'd7;
    case (st)
      ENTER: stage_o = 3'd0;
      ID_SH: stage_o = 3'd1;
      ER_SH, ER_WT: stage_o = 3'd2;
      PG_SH, PG_WT: stage_o = 3'd3;
      VF_SH, VF_WT, VF_RD: stage_o = 3'd4;
      EXIT: stage_o = 3'd5;
      default: stage_o = 3'd7;
    endcase
    case (st)
      ER_SH: shift_op_o = 3'd1;
      PG_SH: shift_op_o = 3'd2;
      VF_SH: shift_op_o = 3'd3;
      VF_RD: shift_op_o = 3'd4;
      default: shift_op_o = 3'd0;
    endcase
  end

  assign shift_req_o   = (st == ID_SH) || (st == ER_SH) || (st == PG_SH) ||
                         (st == VF_SH) || (st == VF_RD);
  assign pulse_o       = (st == ER_WT) || (st == PG_WT) || (st == VF_WT);
  assign shift_addr_o  = addr;
  assign shift_wdata_o = exp_data_i;
  assign busy_o        = (st != IDLE);
  assign done_o        = done_q;
  assign pass_o        = pass_q;
endmodule

module isp_seq_ctrl_chk #(parameter int AW = 1) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic [2:0]    stage_o,
  input logic          shift_req_o,
  input logic          shift_done_i,
  input logic [2:0]    shift_op_o,
  input logic [AW-1:0] shift_addr_o,
  input logic          pulse_o
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    shift_req_o && !shift_done_i |=> shift_req_o && $stable(shift_op_o) && $stable(shift_addr_o));
  assert_req_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_req_o && pulse_o));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_ends_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o));
  assert_pass_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(pass_o));
  assert_stage_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> stage_o >= $past(stage_o));
  assert_idle_stage_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> stage_o == 3'd7 && !shift_req_o && !pulse_o);
  assert_pulse_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> stage_o >= 3'd2 && stage_o <= 3'd4);
endmodule

bind isp_seq_ctrl isp_seq_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .pass_o(pass_o), .stage_o(stage_o), .shift_req_o(shift_req_o),
  .shift_done_i(shift_done_i), .shift_op_o(shift_op_o), .shift_addr_o(shift_addr_o),
  .pulse_o(pulse_o)
);

// File: tb/sim_isp_seq_ctrl.sv
module sim_isp_seq_ctrl;
  localparam int CPM = 10, EMS = 3, PCYC = 3, RCYC = 2, N = 4, DW = 8, LAT = 2;
  localparam logic [7:0] IDV = 8'hA5;

  logic clk = 0, rst_n = 0, start = 0, vonly = 0;
  logic sreq, sdone = 0, pulse, busy, done, pass;
  logic [2:0] op, stage;
  logic [1:0] addr;
  logic [7:0] wdata, rdata = 0, expd;
  int checks = 0, fails = 0;
  int rcnt = 0, pg_cnt = 0, va_cnt = 0, rd_cnt = 0, er_cnt = 0, id_cnt = 0;
  int bad_id = 0, corrupt = -1, addr_ok = 1, wdata_ok = 1;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  assign expd = pat(int'(addr));

  isp_seq_ctrl #(.CPM(CPM), .ERASE_MS(EMS), .PROG_CYC(PCYC), .READ_CYC(RCYC),
    .ADDRS(N), .DW(DW), .ID_VAL(IDV)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .verify_only_i(vonly),
    .shift_req_o(sreq), .shift_op_o(op), .shift_addr_o(addr), .shift_wdata_o(wdata),
    .shift_done_i(sdone), .shift_rdata_i(rdata), .exp_data_i(expd),
    .pulse_o(pulse), .busy_o(busy), .done_o(done), .pass_o(pass), .stage_o(stage));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    sdone = 0;
    if (sreq) begin
      if (rcnt == LAT - 1) begin
        rcnt = 0;
        sdone = 1;
        case (op)
          3'd0: begin id_cnt++; rdata = bad_id ? (IDV ^ 8'h01) : IDV; end
          3'd1: er_cnt++;
          3'd2: begin
            if (int'(addr) != pg_cnt) addr_ok = 0;
            if (wdata != pat(int'(addr))) wdata_ok = 0;
            pg_cnt++;
          end
          3'd3: begin if (int'(addr) != va_cnt) addr_ok = 0; va_cnt++; end
          default: begin
            if (int'(addr) != rd_cnt) addr_ok = 0;
            rdata = pat(int'(addr)) ^ ((int'(addr) == corrupt) ? 8'h10 : 8'h00);
            rd_cnt++;
          end
        endcase
      end else rcnt++;
    end else rcnt = 0;
  end

  task automatic run(input bit mode, input int bid, input int cor);
    int cyc = 0, seq = 0, last = 7, ep = 0, pp = 0, vp = 0, t, es;
    bit exp_pass;
    bad_id = bid; corrupt = cor;
    pg_cnt = 0; va_cnt = 0; rd_cnt = 0; er_cnt = 0; id_cnt = 0; addr_ok = 1; wdata_ok = 1;
    exp_pass = (bid == 0) && (cor < 0);
    @(negedge clk);
    start = 1; vonly = mode;
    forever begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc == 1) begin
        start = 0;
        chk(busy && !pass, "R10 start clears pass", int'(pass), 0);
      end
      if (cyc == 5) begin start = 1; vonly = !mode; end
      if (cyc == 6) start = 0;
      if (busy && int'(stage) != last) begin seq = (seq << 3) | int'(stage); last = int'(stage); end
      if (pulse && stage == 3'd2) ep++;
      if (pulse && stage == 3'd3) pp++;
      if (pulse && stage == 3'd4) vp++;
      if (done || cyc > 5000) break;
    end
    if (bid != 0) begin t = 2*CPM + LAT; es = 32'o015; end
    else if (mode) begin t = 2*CPM + LAT + N*(2*LAT + RCYC); es = 32'o0145; end
    else begin t = 2*CPM + 2*LAT + EMS*CPM + N*(LAT + PCYC) + N*(2*LAT + RCYC); es = 32'o012345; end
    chk(cyc == t + 1, "R4 R9 start-to-done cycles", cyc, t + 1);
    chk(done && !busy, "R10 done with busy low", int'(busy), 0);
    chk(pass == exp_pass, "R7 R8 result", int'(pass), int'(exp_pass));
    chk(seq == es, mode ? "R3 stage order" : "R2 stage order", seq, es);
    chk(ep == ((bid == 0 && !mode) ? EMS*CPM : 0), "R5 erase pulse length", ep, EMS*CPM);
    chk(er_cnt == ((bid == 0 && !mode) ? 1 : 0), "R5 R3 erase shifts", er_cnt, 1);
    chk(pg_cnt == ((bid == 0 && !mode) ? N : 0), "R6 R3 program shifts", pg_cnt, N);
    chk(pp == ((bid == 0 && !mode) ? N*PCYC : 0), "R6 program pulse cycles", pp, N*PCYC);
    chk(rd_cnt == ((bid == 0) ? N : 0) && va_cnt == rd_cnt, "R7 verify shifts", rd_cnt, N);
    chk(vp == ((bid == 0) ? N*RCYC : 0), "R7 read pulse cycles", vp, N*RCYC);
    chk(addr_ok == 1 && wdata_ok == 1, "R6 R7 address order and data", addr_ok, 1);
    chk(id_cnt == 1, "R8 one ID shift", id_cnt, 1);
    @(negedge clk);
    chk(!done, "R10 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(pass == exp_pass && !busy, "R10 pass held", int'(pass), int'(exp_pass));
  endtask

  initial begin
    #1;
    chk(!busy && !done && !pass && !sreq && !pulse && stage == 3'd7, "R1 reset state", int'(stage), 7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !pass && !sreq && !pulse && stage == 3'd7, "R1 after reset", int'(busy), 0);
    for (int m = 0; m < 2; m++) begin
      run(m[0], 0, -1);
      run(m[0], 1, -1);
      for (int c = 0; c < N; c++) run(m[0], 0, c);
    end
    run(1'b0, 0, -1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule